// File: doc/BRIEF.md
# Ten-Level Price Ladder with Feed Sequence Recovery

This block keeps a depth-limited price ladder for one instrument, ten levels on the buy side and ten on the sell side, from a stream of already-decoded market data records. Each level holds a price and an aggregate resting size. A record is one of three kinds: an incremental update (insert, overwrite or remove at a level), a snapshot record that loads one level directly, or a trade print. The full ladder, the top of each side and any trade print are presented on registered outputs for a quoting engine downstream.

Packets carry a sequence number, checked on the first record of each packet. A mismatch declares a feed gap. The block then throws away the whole ladder, raises a desynchronised flag so that quoting can be held off, and ignores incremental traffic. It still notes the highest sequence number seen. The ladder is rebuilt from a run of snapshot records. Trust returns only when a complete snapshot covers every incremental packet seen during the outage.

Records arrive at most one per clock. Every effect of a record appears at the first rising edge after it is presented.

Top module: `lob_ladder`

## Requirements
- R1: During and after a synchronous active-high reset every ladder level holds price 0 and size 0, `book_desync` is 1, and `best_upd`, `trade_valid` and `feed_gap` are 0.
- R2: While desynchronised, a snapshot record (kind 1) with `rec_first`=1 clears both sides and then writes its price and size at (`rec_side`, `rec_level`). Later snapshot records of the same run only write their level. On the record with `rec_last`=1 the run's sequence number (taken from its first record) is compared with the highest incremental sequence seen. If it is equal or larger, `book_desync` falls and the next expected sequence becomes that number plus one.
- R3: A snapshot run whose sequence number is below the highest incremental sequence seen while desynchronised leaves `book_desync` at 1, while its levels are still loaded.
- R4: An in-sync incremental (kind 0) with action 0 (insert) at level N moves levels N..8 to N+1..9, drops the old level 9 and writes the record at level N. Level 0 is the best level. Side 0 is bid and side 1 is ask. Level j sits at bits [j*W +: W] of the flat ladder outputs.
- R5: An in-sync incremental with action 1 (overwrite) replaces price and size at level N only.
- R6: An in-sync incremental with action 2 (remove) at level N moves levels N+1..9 up by one and clears level 9.
- R7: An incremental with `rec_first`=1 whose `rec_seq` differs from the expected value, received while in sync, is not applied. It pulses `feed_gap` for one cycle, sets `book_desync` and clears every level of both sides.
- R8: While desynchronised, incremental records leave the ladder unchanged.
- R9: An incremental with `rec_level` of 10 or more leaves the ladder unchanged. Its sequence number is still consumed.
- R10: The best bid and ask outputs always equal level 0 of each side. `best_upd` pulses for one cycle, one cycle after any record that wrote or cleared the ladder, and stays 0 otherwise.
- R11: A trade record (kind 2) raises `trade_valid` for one cycle, one cycle later, with its price, size and `rec_side` as aggressor side (0 buyer, 1 seller). This happens whether or not the book is in sync, and the ladder is left unchanged.
- R12: Snapshot records that arrive while in sync leave the ladder and the sync state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record present this cycle |
| rec_kind | input | 2 | 0 incremental, 1 snapshot, 2 trade |
| rec_action | input | 2 | Incremental action: 0 insert, 1 overwrite, 2 remove |
| rec_side | input | 1 | 0 bid, 1 ask; aggressor side for trades |
| rec_level | input | LVLW (4) | Target level, 0 = best |
| rec_price | input | PW (32) | Price |
| rec_size | input | SW (32) | Size |
| rec_seq | input | SEQW (32) | Packet sequence number |
| rec_first | input | 1 | First record of a packet or snapshot run |
| rec_last | input | 1 | Last record of a packet or snapshot run |
| bid_px_flat | output | LEVELS*PW | Bid prices, level j at [j*PW +: PW] |
| bid_sz_flat | output | LEVELS*SW | Bid sizes |
| ask_px_flat | output | LEVELS*PW | Ask prices |
| ask_sz_flat | output | LEVELS*SW | Ask sizes |
| best_bid_px | output | PW | Best bid price |
| best_bid_sz | output | SW | Best bid size |
| best_ask_px | output | PW | Best ask price |
| best_ask_sz | output | SW | Best ask size |
| best_upd | output | 1 | Ladder changed on the last edge |
| trade_valid | output | 1 | Trade print this cycle |
| trade_px | output | PW | Trade price |
| trade_sz | output | SW | Trade size |
| trade_aggr | output | 1 | Aggressor side |
| book_desync | output | 1 | Ladder not trustworthy |
| feed_gap | output | 1 | One-cycle pulse on a detected gap |

## Verification
The bench fills the ladder until an insert pushes the deepest level off the end, then removes from the middle. A design with an off-by-one shift would duplicate or lose a level there. It sends a gap followed by a stale snapshot and then a fresh one. A design that trusted the stale snapshot would reopen quoting over missing updates, and one that kept old levels after the gap would show them. It also checks that a mid-packet record with an unrelated sequence number is applied, that an out-of-range level consumes its sequence number without writing, and that a snapshot arriving in sync is ignored. A design that got any of these wrong would corrupt the ladder or declare false gaps.

// File: rtl/lob_pkg.sv
package lob_pkg;

  typedef enum logic [1:0] {
    KIND_INC   = 2'd0,
    KIND_SNAP  = 2'd1,
    KIND_TRADE = 2'd2,
    KIND_RSVD  = 2'd3
  } rec_kind_e;

  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_SET    = 2'd1,
    OP_REMOVE = 2'd2,
    OP_NONE   = 2'd3
  } lvl_op_e;

  localparam int SIDES = 2;

endpackage

// File: rtl/lob_sync.sv
module lob_sync
  import lob_pkg::*;
#(
  parameter int SEQW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rec_valid,
  input  logic [1:0]      rec_kind,
  input  logic            rec_first,
  input  logic            rec_last,
  input  logic [SEQW-1:0] rec_seq,
  output logic            apply_inc,
  output logic            apply_snap,
  output logic            clear_book,
  output logic            in_sync,
  output logic            gap_pulse
);

  logic [SEQW-1:0] exp_seq;
  logic [SEQW-1:0] hi_seen;
  logic [SEQW-1:0] run_seq;
  logic            run_open;
  logic            sync_q;
  logic            gap_q;

  logic            is_inc;
  logic            is_snap;
  logic            seq_ok;
  logic            gap_now;
  logic            run_take;
  logic            run_done;
  logic            run_good;
  logic [SEQW-1:0] run_ref;

  always_comb begin
    is_inc     = rec_valid && (rec_kind_e'(rec_kind) == KIND_INC);
    is_snap    = rec_valid && (rec_kind_e'(rec_kind) == KIND_SNAP);
    seq_ok     = (rec_seq == exp_seq);
    gap_now    = is_inc && sync_q && rec_first && !seq_ok;
    apply_inc  = is_inc && sync_q && (!rec_first || seq_ok);
    run_take   = is_snap && !sync_q && (rec_first || run_open);
    apply_snap = run_take;
    clear_book = gap_now || (is_snap && !sync_q && rec_first);
    run_ref    = rec_first ? rec_seq : run_seq;
    run_done   = run_take && rec_last;
    run_good   = run_done && (run_ref >= hi_seen);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_seq  <= '0;
      hi_seen  <= '0;
      run_seq  <= '0;
      run_open <= 1'b0;
      sync_q   <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      gap_q <= gap_now;
      if (is_inc && sync_q && rec_first && seq_ok) begin
        exp_seq <= rec_seq + 1'b1;
      end
      if (gap_now) begin
        sync_q  <= 1'b0;
        hi_seen <= rec_seq;
      end
      if (is_inc && !sync_q && rec_first && (rec_seq > hi_seen)) begin
        hi_seen <= rec_seq;
      end
      if (is_snap && !sync_q && rec_first) begin
        run_seq  <= rec_seq;
        run_open <= !rec_last;
      end else if (run_done) begin
        run_open <= 1'b0;
      end
      if (run_good) begin
        sync_q  <= 1'b1;
        exp_seq <= run_ref + 1'b1;
      end
    end
  end

  assign in_sync   = sync_q;
  assign gap_pulse = gap_q;

endmodule

// File: rtl/lob_side.sv
module lob_side
  import lob_pkg::*;
#(
  parameter int LEVELS = 10,
  parameter int PW     = 32,
  parameter int SW     = 32,
  parameter int LVLW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [1:0]           op,
  input  logic [LVLW-1:0]      lvl,
  input  logic [PW-1:0]        px_in,
  input  logic [SW-1:0]        sz_in,
  output logic [LEVELS*PW-1:0] px_flat,
  output logic [LEVELS*SW-1:0] sz_flat,
  output logic [PW-1:0]        top_px_nxt,
  output logic [SW-1:0]        top_sz_nxt,
  output logic                 applied
);

  logic [LEVELS-1:0][PW-1:0] px_q, base_px, nxt_px;
  logic [LEVELS-1:0][SW-1:0] sz_q, base_sz, nxt_sz;
  logic                      wr_ok;
  int                        lvl_i;

  always_comb begin
    lvl_i = int'(lvl);
    wr_ok = wr_en && (lvl_i < LEVELS);
    for (int i = 0; i < LEVELS; i++) begin
      base_px[i] = clr ? '0 : px_q[i];
      base_sz[i] = clr ? '0 : sz_q[i];
    end
    nxt_px = base_px;
    nxt_sz = base_sz;
    if (wr_ok) begin
      case (lvl_op_e'(op))
        OP_INSERT: begin
          for (int i = 1; i < LEVELS; i++) begin
            if (i > lvl_i) begin
              nxt_px[i] = base_px[i-1];
              nxt_sz[i] = base_sz[i-1];
            end
          end
          nxt_px[lvl] = px_in;
          nxt_sz[lvl] = sz_in;
        end
        OP_SET: begin
          nxt_px[lvl] = px_in;
          nxt_sz[lvl] = sz_in;
        end
        OP_REMOVE: begin
          for (int i = 0; i < LEVELS-1; i++) begin
            if (i >= lvl_i) begin
              nxt_px[i] = base_px[i+1];
              nxt_sz[i] = base_sz[i+1];
            end
          end
          nxt_px[LEVELS-1] = '0;
          nxt_sz[LEVELS-1] = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      px_q <= '0;
      sz_q <= '0;
    end else begin
      px_q <= nxt_px;
      sz_q <= nxt_sz;
    end
  end

  assign px_flat    = px_q;
  assign sz_flat    = sz_q;
  assign top_px_nxt = nxt_px[0];
  assign top_sz_nxt = nxt_sz[0];
  assign applied    = wr_ok && (lvl_op_e'(op) != OP_NONE);

endmodule

// File: rtl/lob_events.sv
module lob_events #(
  parameter int PW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [PW-1:0] bid_px_nxt,
  input  logic [SW-1:0] bid_sz_nxt,
  input  logic [PW-1:0] ask_px_nxt,
  input  logic [SW-1:0] ask_sz_nxt,
  input  logic          trd_in,
  input  logic [PW-1:0] trd_px_in,
  input  logic [SW-1:0] trd_sz_in,
  input  logic          trd_side_in,
  output logic [PW-1:0] best_bid_px,
  output logic [SW-1:0] best_bid_sz,
  output logic [PW-1:0] best_ask_px,
  output logic [SW-1:0] best_ask_sz,
  output logic          best_upd,
  output logic          trade_valid,
  output logic [PW-1:0] trade_px,
  output logic [SW-1:0] trade_sz,
  output logic          trade_aggr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_bid_px <= '0;
      best_bid_sz <= '0;
      best_ask_px <= '0;
      best_ask_sz <= '0;
      best_upd    <= 1'b0;
      trade_valid <= 1'b0;
      trade_px    <= '0;
      trade_sz    <= '0;
      trade_aggr  <= 1'b0;
    end else begin
      best_upd    <= touch;
      trade_valid <= trd_in;
      if (touch) begin
        best_bid_px <= bid_px_nxt;
        best_bid_sz <= bid_sz_nxt;
        best_ask_px <= ask_px_nxt;
        best_ask_sz <= ask_sz_nxt;
      end
      if (trd_in) begin
        trade_px   <= trd_px_in;
        trade_sz   <= trd_sz_in;
        trade_aggr <= trd_side_in;
      end
    end
  end

endmodule

// File: rtl/lob_ladder.sv
module lob_ladder
  import lob_pkg::*;
#(
  parameter int  LEVELS = 10,
  parameter int  PW     = 32,
  parameter int  SW     = 32,
  parameter int  SEQW   = 32,
  localparam int LVLW   = $clog2(LEVELS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rec_valid,
  input  logic [1:0]           rec_kind,
  input  logic [1:0]           rec_action,
  input  logic                 rec_side,
  input  logic [LVLW-1:0]      rec_level,
  input  logic [PW-1:0]        rec_price,
  input  logic [SW-1:0]        rec_size,
  input  logic [SEQW-1:0]      rec_seq,
  input  logic                 rec_first,
  input  logic                 rec_last,
  output logic [LEVELS*PW-1:0] bid_px_flat,
  output logic [LEVELS*SW-1:0] bid_sz_flat,
  output logic [LEVELS*PW-1:0] ask_px_flat,
  output logic [LEVELS*SW-1:0] ask_sz_flat,
  output logic [PW-1:0]        best_bid_px,
  output logic [SW-1:0]        best_bid_sz,
  output logic [PW-1:0]        best_ask_px,
  output logic [SW-1:0]        best_ask_sz,
  output logic                 best_upd,
  output logic                 trade_valid,
  output logic [PW-1:0]        trade_px,
  output logic [SW-1:0]        trade_sz,
  output logic                 trade_aggr,
  output logic                 book_desync,
  output logic                 feed_gap
);

  logic apply_inc, apply_snap, clear_book, in_sync;
  logic [1:0] side_op;
  logic       trd_in;

  logic [SIDES-1:0][LEVELS*PW-1:0] s_px_flat;
  logic [SIDES-1:0][LEVELS*SW-1:0] s_sz_flat;
  logic [SIDES-1:0][PW-1:0]        s_top_px;
  logic [SIDES-1:0][SW-1:0]        s_top_sz;
  logic [SIDES-1:0]                s_applied;

  lob_sync #(.SEQW(SEQW)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .rec_valid  (rec_valid),
    .rec_kind   (rec_kind),
    .rec_first  (rec_first),
    .rec_last   (rec_last),
    .rec_seq    (rec_seq),
    .apply_inc  (apply_inc),
    .apply_snap (apply_snap),
    .clear_book (clear_book),
    .in_sync    (in_sync),
    .gap_pulse  (feed_gap)
  );

  assign side_op = apply_snap ? OP_SET : rec_action;
  assign trd_in  = rec_valid && (rec_kind_e'(rec_kind) == KIND_TRADE);

  for (genvar s = 0; s < SIDES; s++) begin : gen_side
    lob_side #(
      .LEVELS (LEVELS),
      .PW     (PW),
      .SW     (SW),
      .LVLW   (LVLW)
    ) u_side (
      .clk        (clk),
      .rst        (rst),
      .clr        (clear_book),
      .wr_en      ((apply_inc || apply_snap) && (rec_side == 1'(s))),
      .op         (side_op),
      .lvl        (rec_level),
      .px_in      (rec_price),
      .sz_in      (rec_size),
      .px_flat    (s_px_flat[s]),
      .sz_flat    (s_sz_flat[s]),
      .top_px_nxt (s_top_px[s]),
      .top_sz_nxt (s_top_sz[s]),
      .applied    (s_applied[s])
    );
  end

  lob_events #(.PW(PW), .SW(SW)) u_events (
    .clk         (clk),
    .rst         (rst),
    .touch       ((|s_applied) || clear_book),
    .bid_px_nxt  (s_top_px[0]),
    .bid_sz_nxt  (s_top_sz[0]),
    .ask_px_nxt  (s_top_px[1]),
    .ask_sz_nxt  (s_top_sz[1]),
    .trd_in      (trd_in),
    .trd_px_in   (rec_price),
    .trd_sz_in   (rec_size),
    .trd_side_in (rec_side),
    .best_bid_px (best_bid_px),
    .best_bid_sz (best_bid_sz),
    .best_ask_px (best_ask_px),
    .best_ask_sz (best_ask_sz),
    .best_upd    (best_upd),
    .trade_valid (trade_valid),
    .trade_px    (trade_px),
    .trade_sz    (trade_sz),
    .trade_aggr  (trade_aggr)
  );

  assign bid_px_flat = s_px_flat[0];
  assign bid_sz_flat = s_sz_flat[0];
  assign ask_px_flat = s_px_flat[1];
  assign ask_sz_flat = s_sz_flat[1];
  assign book_desync = !in_sync;

endmodule

// File: rtl/lob_ladder_chk.sv
module lob_ladder_chk #(
  parameter int LEVELS = 10,
  parameter int PW     = 32,
  parameter int SW     = 32,
  parameter int LVLW   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rec_valid,
  input logic [1:0]           rec_kind,
  input logic [LVLW-1:0]      rec_level,
  input logic                 rec_first,
  input logic                 rec_last,
  input logic [PW-1:0]        rec_price,
  input logic [LEVELS*PW-1:0] bid_px_flat,
  input logic [LEVELS*PW-1:0] ask_px_flat,
  input logic [LEVELS*SW-1:0] bid_sz_flat,
  input logic [LEVELS*SW-1:0] ask_sz_flat,
  input logic [PW-1:0]        best_bid_px,
  input logic [PW-1:0]        best_ask_px,
  input logic [SW-1:0]        best_bid_sz,
  input logic [SW-1:0]        best_ask_sz,
  input logic                 trade_valid,
  input logic [PW-1:0]        trade_px,
  input logic                 book_desync,
  input logic                 feed_gap
);

  AST_RESYNC_ON_SNAP_END: assert property (@(posedge clk) disable iff (rst)
    (!book_desync && $past(book_desync)) |-> $past(rec_valid && rec_kind == 2'd1 && rec_last)); // R2

  AST_GAP_DROPS_BOOK: assert property (@(posedge clk) disable iff (rst)
    feed_gap |-> (book_desync && best_bid_sz == '0 && best_ask_sz == '0)); // R7

  AST_DESYNC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (book_desync && rec_valid && rec_kind == 2'd0) |=> ($stable(bid_px_flat) && $stable(ask_px_flat))); // R8

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_kind == 2'd0 && !rec_first && int'(rec_level) >= LEVELS)
      |=> ($stable(bid_px_flat) && $stable(ask_px_flat) && $stable(bid_sz_flat) && $stable(ask_sz_flat))); // R9

  AST_BEST_BID_TOP: assert property (@(posedge clk) disable iff (rst)
    (best_bid_px == bid_px_flat[PW-1:0] && best_bid_sz == bid_sz_flat[SW-1:0])); // R10

  AST_BEST_ASK_TOP: assert property (@(posedge clk) disable iff (rst)
    (best_ask_px == ask_px_flat[PW-1:0] && best_ask_sz == ask_sz_flat[SW-1:0])); // R10

  AST_TRADE_ECHO: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_kind == 2'd2) |=> (trade_valid && trade_px == $past(rec_price))); // R11

  AST_SNAP_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!book_desync && rec_valid && rec_kind == 2'd1) |=> ($stable(bid_px_flat) && $stable(ask_px_flat) && !book_desync)); // R12

endmodule

bind lob_ladder lob_ladder_chk #(
  .LEVELS (LEVELS),
  .PW     (PW),
  .SW     (SW),
  .LVLW   (LVLW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rec_valid   (rec_valid),
  .rec_kind    (rec_kind),
  .rec_level   (rec_level),
  .rec_first   (rec_first),
  .rec_last    (rec_last),
  .rec_price   (rec_price),
  .bid_px_flat (bid_px_flat),
  .ask_px_flat (ask_px_flat),
  .bid_sz_flat (bid_sz_flat),
  .ask_sz_flat (ask_sz_flat),
  .best_bid_px (best_bid_px),
  .best_ask_px (best_ask_px),
  .best_bid_sz (best_bid_sz),
  .best_ask_sz (best_ask_sz),
  .trade_valid (trade_valid),
  .trade_px    (trade_px),
  .book_desync (book_desync),
  .feed_gap    (feed_gap)
);

// File: tb/lob_ladder_tb.sv
module lob_ladder_tb;

  localparam int LEVELS = 10;
  localparam int PW     = 32;
  localparam int SW     = 32;
  localparam int SEQW   = 32;
  localparam int LVLW   = 4;
  localparam int NV     = 17;

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  act;
    logic        side;
    logic [3:0]  lvl;
    logic [31:0] px;
    logic [31:0] sz;
    logic [31:0] seq;
    logic        first;
    logic        last;
    logic        x_desync;
    logic        x_upd;
    logic [31:0] x_bid0;
    logic [31:0] x_ask0;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd0, 1'b0, 4'd0, 32'd100, 32'd5, 32'd10, 1'b1, 1'b0, 1'b1, 1'b1, 32'd100, 32'd0},
    '{2'd1, 2'd0, 1'b0, 4'd1, 32'd99,  32'd7, 32'd0,  1'b0, 1'b0, 1'b1, 1'b1, 32'd100, 32'd0},
    '{2'd1, 2'd0, 1'b1, 4'd0, 32'd101, 32'd4, 32'd0,  1'b0, 1'b1, 1'b0, 1'b1, 32'd100, 32'd101},
    '{2'd0, 2'd0, 1'b0, 4'd0, 32'd110, 32'd1, 32'd11, 1'b1, 1'b1, 1'b0, 1'b1, 32'd110, 32'd101},
    '{2'd0, 2'd2, 1'b0, 4'd0, 32'd0,   32'd0, 32'd12, 1'b1, 1'b1, 1'b0, 1'b1, 32'd100, 32'd101},
    '{2'd0, 2'd1, 1'b1, 4'd0, 32'd102, 32'd3, 32'd13, 1'b1, 1'b1, 1'b0, 1'b1, 32'd100, 32'd102},
    '{2'd0, 2'd0, 1'b1, 4'd0, 32'd101, 32'd2, 32'd14, 1'b1, 1'b0, 1'b0, 1'b1, 32'd100, 32'd101},
    '{2'd0, 2'd1, 1'b0, 4'd0, 32'd100, 32'd9, 32'd99, 1'b0, 1'b1, 1'b0, 1'b1, 32'd100, 32'd101},
    '{2'd0, 2'd0, 1'b0, 4'd0, 32'd120, 32'd1, 32'd20, 1'b1, 1'b1, 1'b1, 1'b1, 32'd0,   32'd0},
    '{2'd0, 2'd0, 1'b0, 4'd0, 32'd130, 32'd1, 32'd21, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0,   32'd0},
    '{2'd1, 2'd0, 1'b0, 4'd0, 32'd140, 32'd2, 32'd18, 1'b1, 1'b1, 1'b1, 1'b1, 32'd140, 32'd0},
    '{2'd1, 2'd0, 1'b1, 4'd0, 32'd145, 32'd2, 32'd21, 1'b1, 1'b1, 1'b0, 1'b1, 32'd0,   32'd145},
    '{2'd0, 2'd0, 1'b0, 4'd0, 32'd139, 32'd1, 32'd22, 1'b1, 1'b1, 1'b0, 1'b1, 32'd139, 32'd145},
    '{2'd2, 2'd0, 1'b1, 4'd0, 32'd141, 32'd6, 32'd0,  1'b1, 1'b1, 1'b0, 1'b0, 32'd139, 32'd145},
    '{2'd1, 2'd0, 1'b1, 4'd0, 32'd999, 32'd1, 32'd50, 1'b1, 1'b1, 1'b0, 1'b0, 32'd139, 32'd145},
    '{2'd0, 2'd1, 1'b1, 4'd10, 32'd1,  32'd1, 32'd23, 1'b1, 1'b1, 1'b0, 1'b0, 32'd139, 32'd145},
    '{2'd0, 2'd1, 1'b1, 4'd0, 32'd146, 32'd1, 32'd24, 1'b1, 1'b1, 1'b0, 1'b1, 32'd139, 32'd146}
  };

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 rec_valid;
  logic [1:0]           rec_kind;
  logic [1:0]           rec_action;
  logic                 rec_side;
  logic [LVLW-1:0]      rec_level;
  logic [PW-1:0]        rec_price;
  logic [SW-1:0]        rec_size;
  logic [SEQW-1:0]      rec_seq;
  logic                 rec_first;
  logic                 rec_last;
  logic [LEVELS*PW-1:0] bid_px_flat, ask_px_flat;
  logic [LEVELS*SW-1:0] bid_sz_flat, ask_sz_flat;
  logic [PW-1:0]        best_bid_px, best_ask_px, trade_px;
  logic [SW-1:0]        best_bid_sz, best_ask_sz, trade_sz;
  logic                 best_upd, trade_valid, trade_aggr, book_desync, feed_gap;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lob_ladder #(.LEVELS(LEVELS), .PW(PW), .SW(SW), .SEQW(SEQW)) u_dut (
    .clk (clk), .rst (rst),
    .rec_valid (rec_valid), .rec_kind (rec_kind), .rec_action (rec_action),
    .rec_side (rec_side), .rec_level (rec_level), .rec_price (rec_price),
    .rec_size (rec_size), .rec_seq (rec_seq), .rec_first (rec_first),
    .rec_last (rec_last),
    .bid_px_flat (bid_px_flat), .bid_sz_flat (bid_sz_flat),
    .ask_px_flat (ask_px_flat), .ask_sz_flat (ask_sz_flat),
    .best_bid_px (best_bid_px), .best_bid_sz (best_bid_sz),
    .best_ask_px (best_ask_px), .best_ask_sz (best_ask_sz),
    .best_upd (best_upd), .trade_valid (trade_valid), .trade_px (trade_px),
    .trade_sz (trade_sz), .trade_aggr (trade_aggr),
    .book_desync (book_desync), .feed_gap (feed_gap)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      3, 6, 12: return "R4";
      4:        return "R6";
      5, 7:     return "R5";
      8:        return "R7";
      9:        return "R8";
      10:       return "R3";
      13:       return "R11";
      14:       return "R12";
      15, 16:   return "R9";
      default:  return "R2";
    endcase
  endfunction

  task automatic send(input logic [1:0] kind, input logic [1:0] act, input logic side,
                      input logic [3:0] lvl, input logic [31:0] px, input logic [31:0] sz,
                      input logic [31:0] seq, input logic first, input logic last);
    @(negedge clk);
    rec_valid  = 1'b1;
    rec_kind   = kind;
    rec_action = act;
    rec_side   = side;
    rec_level  = lvl;
    rec_price  = px;
    rec_size   = sz;
    rec_seq    = seq;
    rec_first  = first;
    rec_last   = last;
    @(negedge clk);
    rec_valid  = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    rec_valid = 1'b0; rec_kind = '0; rec_action = '0; rec_side = 1'b0;
    rec_level = '0; rec_price = '0; rec_size = '0; rec_seq = '0;
    rec_first = 1'b0; rec_last = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 desync", book_desync, 1);
    chk("R1 bid ladder", (|bid_px_flat) | (|bid_sz_flat), 0);
    chk("R1 ask ladder", (|ask_px_flat) | (|ask_sz_flat), 0);
    chk("R1 pulses", {best_upd, trade_valid, feed_gap}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 desync after release", book_desync, 1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].kind, VEC[i].act, VEC[i].side, VEC[i].lvl, VEC[i].px,
           VEC[i].sz, VEC[i].seq, VEC[i].first, VEC[i].last);
      chk({tag_of(i), " desync"}, book_desync, VEC[i].x_desync);
      chk({tag_of(i), " best bid"}, best_bid_px, VEC[i].x_bid0);
      chk({tag_of(i), " best ask"}, best_ask_px, VEC[i].x_ask0);
      chk("R10 best_upd", best_upd, VEC[i].x_upd);
      if (i == 7) chk("R5 overwrite size", best_bid_sz, 9);
      if (i == 8) chk("R7 gap pulse", feed_gap, 1);
      if (i == 9) chk("R7 gap pulse one cycle", feed_gap, 0);
      if (i == 13) begin
        chk("R11 trade valid", trade_valid, 1);
        chk("R11 trade px", trade_px, 141);
        chk("R11 trade sz", trade_sz, 6);
        chk("R11 trade aggr", trade_aggr, 1);
      end
    end

    // R4: fill beyond depth, old level falls off
    for (int k = 0; k < LEVELS; k++) begin
      send(2'd0, 2'd0, 1'b0, 4'd0, 32'(200 + k), 32'(k + 1), 32'(25 + k), 1'b1, 1'b1);
    end
    chk("R4 level0", bid_px_flat[0 +: PW], 209);
    chk("R4 level9", bid_px_flat[9*PW +: PW], 200);
    chk("R4 level9 size", bid_sz_flat[9*SW +: SW], 1);

    // R6: remove in the middle
    send(2'd0, 2'd2, 1'b0, 4'd3, 32'd0, 32'd0, 32'd35, 1'b1, 1'b1);
    chk("R6 level2", bid_px_flat[2*PW +: PW], 207);
    chk("R6 level3", bid_px_flat[3*PW +: PW], 205);
    chk("R6 level8", bid_px_flat[8*PW +: PW], 200);
    chk("R6 level9 cleared", {bid_px_flat[9*PW +: PW], bid_sz_flat[9*SW +: SW]}, 0);

    // R11: trade leaves ladder alone, pulse lasts one cycle
    send(2'd2, 2'd0, 1'b0, 4'd0, 32'd77, 32'd3, 32'd0, 1'b1, 1'b1);
    chk("R11 trade aggr buyer", trade_valid && !trade_aggr, 1);
    chk("R11 trade px", trade_px, 77);
    chk("R11 ladder unchanged", bid_px_flat[0 +: PW], 209);
    chk("R11 no best_upd", best_upd, 0);
    @(negedge clk);
    chk("R11 trade single cycle", trade_valid, 0);

    finish_run();
  end

endmodule